// File: doc/BRIEF.md
# Two-Channel Pin Activity Monitor with Search Qualifier

The block watches two general-purpose input pins. Each pin passes through a two-stage synchronizer and a stability filter, so a new level counts only once it has held for a set number of clocks. Every accepted level change, in either direction, sets a sticky activity flag for that channel. The flags stay set until a clear strobe arrives or the block is reset.

From these signals the block forms one registered qualifier bit that a device-search engine can consume. For each channel a polarity bit names the level that counts as a match. A source bit picks whether the matched signals are the activity flags or the synchronized live pin levels. A mask chooses which channels take part. A combine bit decides whether one matching channel is enough or whether every selected channel must match.

Three byte-wide registers sit on a simple address/data bus: flag status (read-only), channel mask, and control. A separate strobe clears the flags.

Top module: `pio_watch`

## Requirements
- R1: A level change on a pin, rising or falling, that stays unchanged for FILT_CYC consecutive synchronized samples sets that channel's activity flag, and the flag stays set while no clear occurs.
- R2: A pin pulse shorter than FILT_CYC synchronized samples never sets the activity flag.
- R3: Reading address 0x0222 returns the activity flags in bits 1:0 (bit 0 = channel 0) with bits 7:2 zero; writes to this address have no effect.
- R4: A one-cycle high on `clr_i` clears both flags. If an accepted edge occurs in the same cycle, that channel's flag ends set.
- R5: Address 0x0223 holds the channel mask in bits 1:0 (1 = channel takes part). Bits 7:2 read 0 and written ones are dropped.
- R6: Address 0x0224 holds control: bit 0 = channel 0 polarity, bit 1 = channel 1 polarity, bit 2 = source (1 = live pins, 0 = flags), bit 3 = combine (1 = all, 0 = any). Bits 7:4 read 0.
- R7: With combine = 0, `hit_o` is 1 exactly when at least one masked channel's signal equals its polarity bit.
- R8: With combine = 1, `hit_o` is 1 exactly when every masked channel's signal equals its polarity bit.
- R9: With an empty mask, `hit_o` equals the combine bit (0 for any, 1 for all).
- R10: The source bit selects between activity flags and synchronized live pin levels as the channel signals.
- R11: `hit_o` is registered: it reflects a register write or state change one clock after that change takes effect.
- R12: After reset, all three registers read 0x00 and `hit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 2 | Asynchronous input pins, bit n = channel n |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write enable for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| clr_i | input | 1 | Activity flag clear strobe |
| hit_o | output | 1 | Registered search qualifier |

## Verification
The qualifier is driven under both combine modes with pin patterns 00, 01, 10 and 11 against several polarity and mask settings. This separates an AND reduction from an OR reduction and shows whether excluded channels are really neutral. The empty mask shows which value an unselected channel contributes. One setting has flags at 00 and live pins at 01, so only the source bit decides the result. Pulses two clocks long and pulses ten clocks long separate filtering from acceptance. A clear strobe that lands in the very cycle of an accepted edge tests the priority between clearing and setting. A randomized stretch of pins, writes and clears is compared every cycle against a behavioural model.

// File: rtl/pio_watch.sv
module pio_watch #(
  parameter int FILT_CYC = 4,
  parameter logic [15:0] A_FLAG = 16'h0222,
  parameter logic [15:0] A_MASK = 16'h0223,
  parameter logic [15:0] A_CTRL = 16'h0224
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  pin_i,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        clr_i,
  output logic        hit_o
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] CLAST = CW'(FILT_CYC - 1);

  logic [1:0] s1_q, s2_q, flt_q, acc;
  logic [1:0] flag_q, mask_q;
  logic [3:0] ctrl_q;
  logic       hit_q;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [CW-1:0] cnt_q;
    assign acc[g] = (s2_q[g] != flt_q[g]) && (cnt_q == CLAST);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g]  <= 1'b0;
        s2_q[g]  <= 1'b0;
        flt_q[g] <= 1'b0;
        cnt_q    <= '0;
      end else begin
        s1_q[g] <= pin_i[g];
        s2_q[g] <= s1_q[g];
        if (s2_q[g] == flt_q[g]) cnt_q <= '0;
        else if (acc[g]) begin
          flt_q[g] <= s2_q[g];
          cnt_q    <= '0;
        end else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  wire [1:0] sig   = ctrl_q[2] ? s2_q : flag_q;
  wire [1:0] match = ~(sig ^ ctrl_q[1:0]);
  wire       any_m = |(match & mask_q);
  wire       all_m = &(match | ~mask_q);
  wire       hit_d = ctrl_q[3] ? all_m : any_m;
  wire       unused_wd = ^bus_wdata[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      flag_q <= (clr_i ? 2'b00 : flag_q) | acc;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[3:0];
      hit_q <= hit_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_FLAG:  bus_rdata = {6'b0, flag_q};
      A_MASK:  bus_rdata = {6'b0, mask_q};
      A_CTRL:  bus_rdata = {4'b0, ctrl_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/pio_watch_chk.sv
module pio_watch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_i,
  input logic [1:0]  acc,
  input logic [1:0]  flag_q,
  input logic [1:0]  flt_q,
  input logic [1:0]  mask_q,
  input logic [3:0]  ctrl_q,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_rdata,
  input logic        hit_o
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R1
  AST_FLAG_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == 2'b00) |=> ((flag_q & ~$past(acc)) == 2'b00)); // R1
  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == 2'b00) |=> $stable(flt_q)); // R2
  AST_FLAG_READ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 16'h0222) |-> (bus_rdata[7:2] == 6'b0)); // R3
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && acc == 2'b00) |=> (flag_q == 2'b00)); // R4
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != 2'b00) |=> ((flag_q & $past(acc)) == $past(acc))); // R4
  AST_MASK_READ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 16'h0223) |-> (bus_rdata[7:2] == 6'b0)); // R5
  AST_CTRL_READ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 16'h0224) |-> (bus_rdata[7:4] == 4'b0)); // R6
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b00) |=> (hit_o == $past(ctrl_q[3]))); // R9
endmodule

bind pio_watch pio_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .acc(acc), .flag_q(flag_q),
  .flt_q(flt_q), .mask_q(mask_q), .ctrl_q(ctrl_q), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .hit_o(hit_o)
);

// File: tb/test_pio_watch.sv
`timescale 1ns/1ps
module test_pio_watch;
  localparam int F = 4;
  logic clk = 0, rst_n = 0, bus_wr = 0, clr_i = 0;
  logic [1:0] pin_i = 0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic hit_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  pio_watch #(.FILT_CYC(F)) i_pio_watch (.clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clr_i(clr_i), .hit_o(hit_o));

  always #2 clk = ~clk;

  // behavioural reference
  bit [1:0] m_s1, m_s2, m_flt, m_flag, m_mask;
  bit [3:0] m_ctrl;
  bit m_hit;
  int m_cnt[2];

  function automatic bit m_qual();
    bit [1:0] v = m_ctrl[2] ? m_s2 : m_flag;
    int hits = 0, sel = 0;
    for (int c = 0; c < 2; c++)
      if (m_mask[c]) begin sel++; if (v[c] == m_ctrl[c]) hits++; end
    return m_ctrl[3] ? (hits == sel) : (hits > 0);
  endfunction

  function automatic bit [7:0] m_read(input bit [15:0] a);
    if (a == 16'h0222) return {6'b0, m_flag};
    if (a == 16'h0223) return {6'b0, m_mask};
    if (a == 16'h0224) return {4'b0, m_ctrl};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_flt = 0; m_flag = 0; m_mask = 0; m_ctrl = 0; m_hit = 0;
      m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      bit nh;
      bit [1:0] seen;
      nh = m_qual();
      seen = 0;
      for (int c = 0; c < 2; c++) begin
        if (m_s2[c] == m_flt[c]) m_cnt[c] = 0;
        else if (m_cnt[c] == F - 1) begin seen[c] = 1; m_flt[c] = m_s2[c]; m_cnt[c] = 0; end
        else m_cnt[c]++;
      end
      m_s2 = m_s1; m_s1 = pin_i;
      if (clr_i) m_flag = 0;
      m_flag |= seen;
      if (bus_wr && bus_addr == 16'h0223) m_mask = bus_wdata[1:0];
      if (bus_wr && bus_addr == 16'h0224) m_ctrl = bus_wdata[3:0];
      m_hit = nh;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R11 hit vs model", hit_o, m_hit);
      chk("R3 read vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input bit [15:0] a, input bit [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input string tag, input bit [15:0] a, input int exp);
    @(negedge clk); bus_addr = a; #0.5; chk(tag, bus_rdata, exp);
  endtask
  task automatic clr();
    @(negedge clk); clr_i = 1; @(negedge clk); clr_i = 0;
  endtask
  task automatic setpin(input bit [1:0] p); @(negedge clk); pin_i = p; endtask

  initial begin
    idle(3); rst_n = 1;
    rd("R12 flag reset", 16'h0222, 0);
    rd("R12 mask reset", 16'h0223, 0);
    rd("R12 ctrl reset", 16'h0224, 0);
    chk("R12 hit reset", hit_o, 0);
    chk("R9 empty mask any", hit_o, 0);
    // R11 timing on a combine write
    wr(16'h0224, 8'h08);
    #0.5 chk("R11 hit before update", hit_o, 0);
    @(negedge clk); #0.5 chk("R9 empty mask all", hit_o, 1);
    // register field widths
    wr(16'h0222, 8'hFF); rd("R3 flag write ignored", 16'h0222, 0);
    wr(16'h0223, 8'hFF); rd("R5 mask high bits", 16'h0223, 8'h03);
    wr(16'h0224, 8'hFF); rd("R6 ctrl high bits", 16'h0224, 8'h0F);
    wr(16'h0223, 8'h00); wr(16'h0224, 8'h00);
    // filtering
    setpin(2'b01); idle(1); setpin(2'b00); idle(10);
    rd("R2 short pulse", 16'h0222, 0);
    setpin(2'b01); idle(10); rd("R1 rising sets", 16'h0222, 1);
    setpin(2'b00); idle(10); rd("R1 sticky", 16'h0222, 1);
    setpin(2'b01); idle(10);
    clr(); rd("R4 clear", 16'h0222, 0);
    setpin(2'b00); idle(10); rd("R1 falling sets", 16'h0222, 1);
    clr();
    // clear in the same cycle as an accepted edge on channel 1
    setpin(2'b10); idle(4); @(negedge clk); clr_i = 1; @(negedge clk); clr_i = 0;
    rd("R4 edge beats clear", 16'h0222, 2);
    // source select: flags 00, live pins 01
    setpin(2'b01); idle(10); clr(); idle(2);
    rd("R4 flags cleared", 16'h0222, 0);
    wr(16'h0223, 8'h01); wr(16'h0224, 8'h01); idle(3);
    chk("R10 flag source", hit_o, 0);
    wr(16'h0224, 8'h05); idle(3);
    chk("R10 live source", hit_o, 1);
    // any / all with live pins, polarity 11
    wr(16'h0223, 8'h03); wr(16'h0224, 8'h07); idle(3);
    chk("R7 any with 01", hit_o, 1);
    wr(16'h0224, 8'h0F); idle(3);
    chk("R8 all with 01", hit_o, 0);
    setpin(2'b11); idle(6);
    chk("R8 all with 11", hit_o, 1);
    wr(16'h0224, 8'h0C); setpin(2'b00); idle(6);
    chk("R8 all polarity 00", hit_o, 1);
    setpin(2'b10); idle(6);
    chk("R8 all with 10", hit_o, 0);
    wr(16'h0224, 8'h04); idle(3);
    chk("R7 any with 10", hit_o, 1);
    setpin(2'b11); idle(6);
    chk("R7 any none match", hit_o, 0);
    wr(16'h0223, 8'h00); idle(3);
    chk("R9 empty any", hit_o, 0);
    // randomized stretch compared by the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) pin_i = 2'($urandom);
      clr_i = ($urandom_range(0, 20) == 0);
      bus_wr = ($urandom_range(0, 6) == 0);
      bus_addr = 16'h0222 + 16'($urandom_range(0, 3));
      bus_wdata = 8'($urandom);
    end
    @(negedge clk); bus_wr = 0; clr_i = 0;
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule